// File: doc/BRIEF.md
# Thread Block Dispatcher

This block spreads the thread blocks of one compute grid over an array of SIMD cores. A grid descriptor gives the number of blocks, the threads in each block, the registers each thread needs and the shared-memory bytes each block needs. The dispatcher checks once that a single block can fit on an empty core. It then hands out blocks in ascending ID order. Each block goes whole to a core that still has room in all four of its budgets: resident block slots, thread slots, register file and shared memory.

Each assignment carries the core, the block ID, the index of the block's first warp within the grid and the number of 32-thread warps the block is cut into. Cores report finished blocks on a completion port, and the dispatcher returns that block's resources to the core. When no core can take the next block, dispatch waits until a completion frees room. Once every block has been dispatched and reported complete, a done flag rises. Only one grid is in flight at a time.

The grid descriptor input and the assignment output are valid/ready streams. A descriptor is taken only on a cycle where both `grid_valid` and `grid_ready` are high. `grid_ready` is high only while no grid is running. An assignment moves on each cycle where `asg_valid` and `asg_ready` are both high. While `asg_ready` is low, the offered assignment stays unchanged. The resources for an assignment are charged to its core as soon as it is offered.

Top module: `tblk_dispatch`

## Requirements
- R1: `grid_ready` is high exactly when no grid is running. A descriptor handshake starts a grid, and no assignment is offered while `grid_ready` is high.
- R2: A descriptor is rejected when any of these holds: the block count is zero, the thread count is zero, the thread count exceeds 768, threads × registers-per-thread exceeds 8192, or shared memory exceeds 16384 bytes. A rejected descriptor is consumed, sets `grid_err` and produces no assignment. `grid_err` clears on the next accepted descriptor.
- R3: Blocks are assigned in ascending ID starting at 0. `asg_warp_base` equals the block ID × the grid's warps per block.
- R4: `asg_warp_cnt` equals the thread count divided by 32, rounded up.
- R5: The core for a block is the first core that can hold it, scanning upward and wrapping from the core after the last assigned core. After reset the scan starts at core 0.
- R6: A core holds at most 8 blocks, 768 threads, 8192 registers and 16384 shared-memory bytes. When the next block fits no core, no assignment is offered.
- R7: A completion (`cmp_valid` with `cmp_core`) releases one block's resources on that core. A completion is ignored while no grid runs or when that core holds no block.
- R8: A release and a new assignment on the same core in the same cycle both take effect.
- R9: While `asg_valid` is high and `asg_ready` is low, all assignment fields stay stable.
- R10: `grid_done` rises once all blocks are dispatched and all have completed. It stays high until the next descriptor handshake.
- R11: After reset, `grid_ready` is 1 and `asg_valid`, `grid_done` and `grid_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grid_valid | input | 1 | Descriptor offered |
| grid_ready | output | 1 | Descriptor can be taken (idle) |
| grid_nblk | input | 16 | Blocks in the grid |
| grid_thr | input | 10 | Threads per block |
| grid_rpt | input | 8 | Registers per thread |
| grid_smem | input | 15 | Shared-memory bytes per block |
| asg_valid | output | 1 | Assignment offered |
| asg_ready | input | 1 | Assignment accepted |
| asg_core | output | 4 | Target core |
| asg_block | output | 16 | Block ID |
| asg_warp_base | output | 22 | First warp index of the block in the grid |
| asg_warp_cnt | output | 6 | Warps in the block |
| cmp_valid | input | 1 | Block completion report |
| cmp_core | input | 4 | Core that finished a block |
| grid_done | output | 1 | Whole grid finished |
| grid_err | output | 1 | Last descriptor rejected |

## Verification
The two functions that can land in the same cycle are the release of a finished block and the charging of a new assignment, both on one core's ledger. The bench first fills every core to its thread limit with 384-thread blocks. It then sends two back-to-back completions to one core, timed so that the second one arrives on the edge where the dispatcher charges the freed slot to that same core. The ledger must then still show a free slot, so the next waiting block must also go to that core. If either update is lost, only one more block goes out, or the second lands elsewhere.

// File: rtl/tblk_pkg.sv
package tblk_pkg;
  localparam int unsigned NCORE    = 16;
  localparam int unsigned CORE_W   = $clog2(NCORE);
  localparam int unsigned WARP_SZ  = 32;
  localparam int unsigned MAX_BLK  = 8;
  localparam int unsigned MAX_THR  = 768;
  localparam int unsigned MAX_REG  = 8192;
  localparam int unsigned MAX_SMEM = 16384;
  localparam int unsigned BID_W    = 16;
  localparam int unsigned THR_W    = 10;
  localparam int unsigned RPT_W    = 8;
  localparam int unsigned SMEM_W   = 15;
  localparam int unsigned WCNT_W   = THR_W - $clog2(WARP_SZ) + 1;
  localparam int unsigned WB_W     = BID_W + WCNT_W;
  localparam int unsigned USE_W    = THR_W + RPT_W + 2;
  localparam int unsigned BCNT_W   = $clog2(MAX_BLK + 1);

  // per-block cost charged against a core's budgets
  typedef struct packed {
    logic [USE_W-1:0] thr;
    logic [USE_W-1:0] regs;
    logic [USE_W-1:0] smem;
  } cost_t;
endpackage

// File: rtl/tblk_ledger.sv
module tblk_ledger
  import tblk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cost_t cost,
  input  logic  take,
  input  logic  give,
  output logic  fits,
  output logic  busy
);
  logic [BCNT_W-1:0] blk_cnt;
  logic [USE_W-1:0]  thr_used, reg_used, smem_used;
  logic              rel;

  assign busy = (blk_cnt != '0);
  assign rel  = give && busy;
  assign fits = (blk_cnt < BCNT_W'(MAX_BLK))
             && (thr_used  + cost.thr  <= USE_W'(MAX_THR))
             && (reg_used  + cost.regs <= USE_W'(MAX_REG))
             && (smem_used + cost.smem <= USE_W'(MAX_SMEM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_cnt   <= '0;
      thr_used  <= '0;
      reg_used  <= '0;
      smem_used <= '0;
    end else begin
      if (take && !rel)      blk_cnt <= blk_cnt + 1'b1;
      else if (rel && !take) blk_cnt <= blk_cnt - 1'b1;
      thr_used  <= thr_used  + (take ? cost.thr  : '0) - (rel ? cost.thr  : '0);
      reg_used  <= reg_used  + (take ? cost.regs : '0) - (rel ? cost.regs : '0);
      smem_used <= smem_used + (take ? cost.smem : '0) - (rel ? cost.smem : '0);
    end
  end

  // R6: budgets are never exceeded
  p_budget_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_cnt <= BCNT_W'(MAX_BLK)) && (thr_used <= USE_W'(MAX_THR))
    && (reg_used <= USE_W'(MAX_REG)) && (smem_used <= USE_W'(MAX_SMEM)));

  // R6: a charge only arrives when the block fits
  p_take_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> fits);
endmodule

// File: rtl/tblk_picker.sv
module tblk_picker #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0] fit,
  input  logic [W-1:0] last,
  output logic         found,
  output logic [W-1:0] pick
);
  logic [W-1:0] idx;

  // rotating first-fit, beginning with the core after the last one used
  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = '0;
    for (int i = 1; i <= int'(N); i++) begin
      idx = W'((int'(last) + i) % int'(N));
      if (!found && fit[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end
endmodule

// File: rtl/tblk_dispatch.sv
module tblk_dispatch
  import tblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grid_valid,
  output logic              grid_ready,
  input  logic [BID_W-1:0]  grid_nblk,
  input  logic [THR_W-1:0]  grid_thr,
  input  logic [RPT_W-1:0]  grid_rpt,
  input  logic [SMEM_W-1:0] grid_smem,
  output logic              asg_valid,
  input  logic              asg_ready,
  output logic [CORE_W-1:0] asg_core,
  output logic [BID_W-1:0]  asg_block,
  output logic [WB_W-1:0]   asg_warp_base,
  output logic [WCNT_W-1:0] asg_warp_cnt,
  input  logic              cmp_valid,
  input  logic [CORE_W-1:0] cmp_core,
  output logic              grid_done,
  output logic              grid_err
);
  localparam int unsigned NC = NCORE;

  logic              running;
  cost_t             cost_q;
  logic [BID_W-1:0]  nblk_q, next_q, done_q;
  logic [WCNT_W-1:0] warps_q;
  logic [WB_W-1:0]   wb_q;
  logic [CORE_W-1:0] last_q;

  logic [USE_W-1:0]  regs_need;
  logic              bad, grid_hs, more, out_free, load, cmp_take, finished;
  logic [NC-1:0]     fit_vec, busy_vec;
  logic              found;
  logic [CORE_W-1:0] pick;

  assign regs_need = USE_W'(grid_thr) * USE_W'(grid_rpt);
  assign bad = (grid_nblk == '0) || (grid_thr == '0)
            || (USE_W'(grid_thr) > USE_W'(MAX_THR))
            || (regs_need > USE_W'(MAX_REG))
            || (USE_W'(grid_smem) > USE_W'(MAX_SMEM));

  assign grid_ready = !running;
  assign grid_hs    = grid_valid && grid_ready;
  assign more       = (next_q != nblk_q);
  assign out_free   = !asg_valid || asg_ready;
  assign load       = running && more && out_free && found;
  assign cmp_take   = running && cmp_valid && busy_vec[cmp_core];
  assign finished   = running && !more && !asg_valid && (done_q == nblk_q);

  for (genvar c = 0; c < NC; c++) begin : g_core
    tblk_ledger u_ledger (
      .clk  (clk),
      .rst_n(rst_n),
      .cost (cost_q),
      .take (load && (pick == CORE_W'(c))),
      .give (running && cmp_valid && (cmp_core == CORE_W'(c))),
      .fits (fit_vec[c]),
      .busy (busy_vec[c])
    );
  end

  tblk_picker #(.N(NC), .W(CORE_W)) u_pick (
    .fit  (fit_vec),
    .last (last_q),
    .found(found),
    .pick (pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running       <= 1'b0;
      cost_q        <= '0;
      nblk_q        <= '0;
      next_q        <= '0;
      done_q        <= '0;
      warps_q       <= '0;
      wb_q          <= '0;
      last_q        <= CORE_W'(NC - 1);
      asg_valid     <= 1'b0;
      asg_core      <= '0;
      asg_block     <= '0;
      asg_warp_base <= '0;
      asg_warp_cnt  <= '0;
      grid_done     <= 1'b0;
      grid_err      <= 1'b0;
    end else begin
      if (grid_hs) begin
        grid_done <= 1'b0;
        grid_err  <= bad;
        if (!bad) begin
          running     <= 1'b1;
          cost_q.thr  <= USE_W'(grid_thr);
          cost_q.regs <= regs_need;
          cost_q.smem <= USE_W'(grid_smem);
          nblk_q      <= grid_nblk;
          next_q      <= '0;
          done_q      <= '0;
          wb_q        <= '0;
          warps_q     <= WCNT_W'((USE_W'(grid_thr) + USE_W'(WARP_SZ - 1)) / USE_W'(WARP_SZ));
        end
      end
      if (load) begin
        asg_valid     <= 1'b1;
        asg_core      <= pick;
        asg_block     <= next_q;
        asg_warp_base <= wb_q;
        asg_warp_cnt  <= warps_q;
        next_q        <= next_q + 1'b1;
        wb_q          <= wb_q + WB_W'(warps_q);
        last_q        <= pick;
      end else if (asg_ready) begin
        asg_valid <= 1'b0;
      end
      if (cmp_take) done_q <= done_q + 1'b1;
      if (finished) begin
        running   <= 1'b0;
        grid_done <= 1'b1;
      end
    end
  end

  // R9: an offered assignment is held while back-pressured
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && !asg_ready) |=> (asg_valid && $stable(asg_core) && $stable(asg_block)
      && $stable(asg_warp_base) && $stable(asg_warp_cnt)));

  // R3: consecutive assignments carry consecutive block IDs
  p_block_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (asg_valid && asg_ready) |=> (!asg_valid || asg_block == $past(asg_block) + 1'b1));

  // R1: nothing is offered while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grid_ready |-> !asg_valid);

  // R10: a finished grid leaves the block idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |-> (grid_ready && !asg_valid && !grid_err));

  // R5: the chosen core is one that fits
  p_pick_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> fit_vec[pick]);
endmodule

// File: tb/sim_tblk_dispatch.sv
module sim_tblk_dispatch;
  import tblk_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grid_valid = 1'b0;
  logic grid_ready;
  logic [BID_W-1:0]  grid_nblk = '0;
  logic [THR_W-1:0]  grid_thr = '0;
  logic [RPT_W-1:0]  grid_rpt = '0;
  logic [SMEM_W-1:0] grid_smem = '0;
  logic asg_valid;
  logic asg_ready = 1'b1;
  logic [CORE_W-1:0] asg_core;
  logic [BID_W-1:0]  asg_block;
  logic [WB_W-1:0]   asg_warp_base;
  logic [WCNT_W-1:0] asg_warp_cnt;
  logic cmp_valid = 1'b0;
  logic [CORE_W-1:0] cmp_core = '0;
  logic grid_done, grid_err;

  always #4 clk = ~clk;

  tblk_dispatch u0 (
    .clk(clk), .rst_n(rst_n),
    .grid_valid(grid_valid), .grid_ready(grid_ready),
    .grid_nblk(grid_nblk), .grid_thr(grid_thr), .grid_rpt(grid_rpt), .grid_smem(grid_smem),
    .asg_valid(asg_valid), .asg_ready(asg_ready), .asg_core(asg_core), .asg_block(asg_block),
    .asg_warp_base(asg_warp_base), .asg_warp_cnt(asg_warp_cnt),
    .cmp_valid(cmp_valid), .cmp_core(cmp_core),
    .grid_done(grid_done), .grid_err(grid_err)
  );

  int nvec = 0;
  int nfail = 0;
  int got = 0;
  int got_core [512];
  int got_blk  [512];
  int got_wb   [512];
  int got_wc   [512];
  int res [16];
  bit finished_run = 1'b0;

  // record every accepted assignment
  always @(negedge clk) begin
    if (rst_n && asg_valid && asg_ready && got < 512) begin
      got_core[got] = int'(asg_core);
      got_blk[got]  = int'(asg_block);
      got_wb[got]   = int'(asg_warp_base);
      got_wc[got]   = int'(asg_warp_cnt);
      res[asg_core] = res[asg_core] + 1;
      got = got + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic send_grid(input int nb, input int thr, input int rpt, input int smem);
    step();
    grid_valid = 1'b1;
    grid_nblk  = BID_W'(nb);
    grid_thr   = THR_W'(thr);
    grid_rpt   = RPT_W'(rpt);
    grid_smem  = SMEM_W'(smem);
    step();
    grid_valid = 1'b0;
  endtask

  task automatic complete(input int core);
    step();
    cmp_valid = 1'b1;
    cmp_core  = CORE_W'(core);
    step();
    cmp_valid = 1'b0;
    if (res[core] > 0) res[core] = res[core] - 1;
  endtask

  task automatic wait_n(input int n);
    int g = 0;
    while (got < n && g < 600) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit any_res();
    bit a = 1'b0;
    for (int c = 0; c < 16; c++) if (res[c] > 0) a = 1'b1;
    return a;
  endfunction

  task automatic drain(input int target);
    int guard = 0;
    while ((got < target || any_res()) && guard < 3000) begin
      for (int c = 0; c < 16; c++) if (res[c] > 0) complete(c);
      step();
      guard++;
    end
  endtask

  task automatic wait_done();
    int g = 0;
    while (!grid_done && g < 30) begin
      @(negedge clk);
      g++;
    end
  endtask

  // nblk, threads, regs/thread, smem, expect error, expect warps
  localparam int NV = 8;
  localparam int VT [NV][6] = '{
    '{3,   64,  8,     0, 0,  2},
    '{2,   33,  4,   100, 0,  2},
    '{1,  769,  1,     0, 1,  0},
    '{1,  768, 10, 16384, 0, 24},
    '{1,  256, 33,     0, 1,  0},
    '{2,    1,  1,     1, 0,  1},
    '{1,   32,  1, 16385, 1,  0},
    '{0,   32,  1,     0, 1,  0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished_run) begin
      nfail++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int base, exp_next, a, b, k, w;
    for (int c = 0; c < 16; c++) res[c] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(1);

    // R11: reset state
    chk(grid_ready == 1'b1, "R11 grid_ready", int'(grid_ready), 1);
    chk(asg_valid == 1'b0, "R11 asg_valid", int'(asg_valid), 0);
    chk(grid_done == 1'b0, "R11 grid_done", int'(grid_done), 0);
    chk(grid_err == 1'b0, "R11 grid_err", int'(grid_err), 0);

    // vector walk: R2 R3 R4 R5 R10
    exp_next = 0;
    for (int v = 0; v < NV; v++) begin
      base = got;
      send_grid(VT[v][0], VT[v][1], VT[v][2], VT[v][3]);
      if (VT[v][4] == 1) begin
        idle(4);
        chk(grid_err == 1'b1, "R2 err flag", int'(grid_err), 1);
        chk(got == base, "R2 no assignment", got - base, 0);
        chk(grid_ready == 1'b1, "R1 ready after reject", int'(grid_ready), 1);
      end else begin
        wait_n(base + VT[v][0]);
        w = VT[v][5];
        chk(grid_err == 1'b0, "R2 err cleared", int'(grid_err), 0);
        for (k = 0; k < VT[v][0]; k++) begin
          chk(got_core[base+k] == (exp_next + k) % 16, "R5 rotation core", got_core[base+k], (exp_next + k) % 16);
          chk(got_blk[base+k] == k, "R3 block id", got_blk[base+k], k);
          chk(got_wb[base+k] == k * w, "R3 warp base", got_wb[base+k], k * w);
          chk(got_wc[base+k] == w, "R4 warp count", got_wc[base+k], w);
        end
        chk(grid_ready == 1'b0, "R1 busy while running", int'(grid_ready), 0);
        exp_next = (got_core[got-1] + 1) % 16;
        drain(base + VT[v][0]);
        wait_done();
        chk(grid_done == 1'b1, "R10 done", int'(grid_done), 1);
      end
    end

    // R6 thread budget: one 768-thread block per core, then stall
    base = got;
    send_grid(20, 768, 1, 0);
    wait_n(base + 16);
    chk(grid_done == 1'b0, "R10 done cleared by handshake", int'(grid_done), 0);
    idle(10);
    chk(got == base + 16, "R6 thread stall", got - base, 16);
    complete(5);
    wait_n(base + 17);
    chk(got_core[base+16] == 5, "R5 R7 freed core reused", got_core[base+16], 5);
    chk(got_blk[base+16] == 16, "R3 block after stall", got_blk[base+16], 16);
    drain(base + 20);
    wait_done();
    chk(grid_done == 1'b1, "R10 done after stall", int'(grid_done), 1);

    // R6 block-slot budget: 8 per core
    base = got;
    send_grid(129, 32, 1, 0);
    wait_n(base + 128);
    idle(10);
    chk(got == base + 128, "R6 block slot stall", got - base, 128);
    drain(base + 129);
    wait_done();

    // R6 register budget: 4096 regs per block, two per core
    base = got;
    send_grid(33, 256, 16, 0);
    wait_n(base + 32);
    idle(10);
    chk(got == base + 32, "R6 register stall", got - base, 32);
    drain(base + 33);
    wait_done();

    // R6 shared-memory budget: 8192 bytes per block, two per core
    base = got;
    send_grid(33, 32, 1, 8192);
    wait_n(base + 32);
    idle(10);
    chk(got == base + 32, "R6 smem stall", got - base, 32);
    drain(base + 33);
    wait_done();

    // R9 back-pressure
    base = got;
    step();
    asg_ready = 1'b0;
    send_grid(2, 32, 1, 0);
    idle(3);
    chk(asg_valid == 1'b1, "R9 offered", int'(asg_valid), 1);
    a = int'(asg_core);
    idle(5);
    chk(asg_valid == 1'b1 && int'(asg_block) == 0, "R9 held block", int'(asg_block), 0);
    chk(int'(asg_core) == a, "R9 held core", int'(asg_core), a);
    step();
    asg_ready = 1'b1;
    drain(base + 2);
    wait_done();
    chk(got_blk[base] == 0 && got_blk[base+1] == 1, "R9 order after release", got_blk[base+1], 1);

    // R7 spurious completion on an empty core is ignored
    base = got;
    send_grid(2, 768, 1, 0);
    wait_n(base + 2);
    a = got_core[base];
    b = got_core[base+1];
    complete((b + 1) % 16);
    complete(a);
    idle(4);
    chk(grid_done == 1'b0, "R7 empty-core completion ignored", int'(grid_done), 0);
    complete(b);
    wait_done();
    chk(grid_done == 1'b1, "R10 done after both", int'(grid_done), 1);

    // R8 release and charge on the same core in one cycle
    base = got;
    send_grid(34, 384, 1, 0);
    wait_n(base + 32);
    idle(5);
    chk(got == base + 32, "R6 full at two blocks per core", got - base, 32);
    step();
    cmp_valid = 1'b1;
    cmp_core  = 4'd3;
    step();
    step();
    cmp_valid = 1'b0;
    res[3] = res[3] - 2;
    wait_n(base + 34);
    chk(got == base + 34, "R8 both blocks issued", got - base, 34);
    chk(got_core[base+32] == 3, "R8 first reuse core", got_core[base+32], 3);
    chk(got_core[base+33] == 3, "R8 second reuse core", got_core[base+33], 3);
    drain(base + 34);
    wait_done();
    chk(grid_done == 1'b1, "R10 final done", int'(grid_done), 1);

    finished_run = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule